// File: doc/BRIEF.md
# Debug Memory Access Command Executor

This block sits between the frame receiver and the serial transmitter of an on-chip debug link. The receiver presents a checked command (function code, length and a payload buffer that the executor reads byte by byte through an index port). The executor carries the command out as master of a byte-wide memory bus with a 16-bit address. It then streams a reply frame to the transmitter over a ready/valid handshake. Only after the last reply byte has been taken does it accept the command.

Six functions are served: a target status query, a block memory read, a block memory write checked by read-back, a multi-byte "set" that returns the values it overwrote (used for planting breakpoints), and unverified single-byte port input and output. Any other code gets an error reply. The page byte found in some payloads is ignored.

Top module: `dbg_cmd_exec`

## Requirements
- R1: After reset, tx_valid, cmd_accept, mem_rd and mem_wr are all low.
- R2: Every reply is function byte, length byte, length data bytes and a checksum byte, for length+3 bytes in total. The checksum is the two's-complement negation of the 8-bit sum of all earlier bytes, so all bytes of a reply add to zero modulo 256.
- R3: Code 0xFF replies with function 0xFF and the 9-byte descriptor 05 80 00 00 00 00 00 01 3F (processor type, buffer size 128, tasking flag, four mapped-limit bytes, breakpoint length, breakpoint opcode).
- R4: Code 0xFE takes payload byte 1 as address low, byte 2 as address high and byte 3 as count. The reply is function 0xFE with length equal to the count, carrying bytes read from consecutive addresses. A count above the buffer depth (128) is cut to 128, and a count of 0 gives an empty reply.
- R5: Code 0xFD writes payload bytes 3 to length-1 to consecutive addresses starting at {byte 2, byte 1}, then reads them all back. The status is 0 when every byte matches and 1 otherwise.
- R6: Code 0xF9 handles length/4 groups of (page, address low, address high, new byte). Each group reads the old byte, writes the new byte, and on the next cycle reads it back. The old bytes are returned in order, with the reply length equal to the number of groups completed.
- R7: When a set-bytes read-back does not match, processing stops. The reply carries only the old bytes gathered before the failing group, and later groups leave memory untouched.
- R8: Code 0xF8 reads the byte at address {payload 1, payload 0} and returns it as a one-byte status.
- R9: Code 0xF7 writes payload byte 2 to address {payload 1, payload 0} without any read strobe and returns status 0.
- R10: Any other code gets function 0xF0, length 1, status 1, with no bus strobe.
- R11: cmd_accept is a one-cycle pulse raised in the cycle after the last reply byte is taken.
- R12: mem_rd and mem_wr are never high in the same cycle. Read data is taken the cycle after mem_rd.
- R13: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A checked command is waiting |
| cmd_fn | input | 8 | Function code of the command |
| cmd_len | input | 8 | Payload length in bytes |
| cmd_accept | output | 1 | Command finished, reply fully sent |
| buf_idx | output | 8 | Payload byte index |
| buf_data | input | 8 | Payload byte at buf_idx (same cycle) |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe, data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| tx_valid | output | 1 | Reply byte valid |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Reply byte |

## Verification
The hardest case to reach is a set-bytes run that fails its read-back in the middle. In that case the reply must be short and the later groups must leave memory alone. The bench memory model has a read-only window at 0xE000-0xEFFF whose reads return the inverted low address byte. A group aimed there fails its verify, and a group after it checks that nothing further is written. The same window forces a mismatch for the block write. A stalling ready pattern on the transmitter exercises the hold and accept timing.

// File: rtl/dbg_exec_pkg.sv
package dbg_exec_pkg;

    localparam logic [7:0] FN_STATUS = 8'hFF;
    localparam logic [7:0] FN_RDMEM  = 8'hFE;
    localparam logic [7:0] FN_WRMEM  = 8'hFD;
    localparam logic [7:0] FN_SETB   = 8'hF9;
    localparam logic [7:0] FN_PIN    = 8'hF8;
    localparam logic [7:0] FN_POUT   = 8'hF7;
    localparam logic [7:0] FN_ERR    = 8'hF0;

    typedef enum logic [4:0] {
        S_IDLE, S_DESC, S_FETCH, S_DISPATCH,
        S_RD_REQ, S_RD_CAP,
        S_WR, S_VRD, S_VCMP,
        S_SB_RD, S_SB_WR, S_SB_VRD, S_SB_CMP,
        S_PIN_CAP, S_STAT, S_SEND, S_WAIT, S_ACK
    } exec_state_e;

    typedef enum logic [2:0] {
        F_IDLE, F_FN, F_LEN, F_DATA, F_SUM
    } frm_state_e;

endpackage

// File: rtl/dbg_reply_buf.sv
module dbg_reply_buf #(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) mem_q[j] <= 8'h00;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];

endmodule

// File: rtl/dbg_tx_framer.sv
module dbg_tx_framer
    import dbg_exec_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       fn,
    input  logic [7:0]       len,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic             done
);

    typedef struct packed {
        frm_state_e state;
        logic [7:0] idx;
        logic [7:0] sum;
    } frm_regs_t;

    frm_regs_t q, d;

    always_comb begin
        d        = q;
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        done     = 1'b0;
        rd_idx   = q.idx[IDX_W-1:0];
        unique case (q.state)
            F_IDLE: if (start) d.state = F_FN;
            F_FN: begin
                tx_valid = 1'b1;
                tx_data  = fn;
                if (tx_ready) begin
                    d.sum   = fn;
                    d.state = F_LEN;
                end
            end
            F_LEN: begin
                tx_valid = 1'b1;
                tx_data  = len;
                if (tx_ready) begin
                    d.sum   = q.sum + len;
                    d.idx   = 8'd0;
                    d.state = (len == 8'd0) ? F_SUM : F_DATA;
                end
            end
            F_DATA: begin
                tx_valid = 1'b1;
                tx_data  = rd_data;
                if (tx_ready) begin
                    d.sum = q.sum + rd_data;
                    d.idx = q.idx + 8'd1;
                    if (q.idx + 8'd1 == len) d.state = F_SUM;
                end
            end
            F_SUM: begin
                tx_valid = 1'b1;
                tx_data  = ~q.sum + 8'd1;
                if (tx_ready) begin
                    done    = 1'b1;
                    d.state = F_IDLE;
                end
            end
            default: d.state = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= F_IDLE;
            q.idx   <= 8'd0;
            q.sum   <= 8'd0;
        end else begin
            q <= d;
        end
    end

    // R13: an offered byte is held until taken
    p_tx_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
    import dbg_exec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BUF_DEPTH = 128,
    parameter int DESC_LEN  = 9,
    parameter logic [DESC_LEN*8-1:0] DESC =
        {8'h05, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h3F},
    localparam int IDX_W = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_fn,
    input  logic [7:0]        cmd_len,
    output logic              cmd_accept,
    output logic [7:0]        buf_idx,
    input  logic [7:0]        buf_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data
);

    typedef struct packed {
        exec_state_e       state;
        logic [7:0]        op;
        logic [7:0]        clen;
        logic [7:0]        rfn;
        logic [7:0]        rlen;
        logic [7:0]        stat;
        logic [3:0][7:0]   arg;
        logic [1:0]        k;
        logic [7:0]        base;
        logic [7:0]        cnt;
        logic [7:0]        i;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        old;
    } exec_regs_t;

    exec_regs_t q, d;

    // descriptor bytes, entry 0 first on the wire
    logic [7:0] desc_byte [DESC_LEN];
    for (genvar g = 0; g < DESC_LEN; g++) begin : g_desc
        assign desc_byte[g] = DESC[(DESC_LEN-1-g)*8 +: 8];
    end

    logic             rb_we;
    logic [IDX_W-1:0] rb_widx;
    logic [7:0]       rb_wdata;
    logic [IDX_W-1:0] rb_ridx;
    logic [7:0]       rb_rdata;
    logic             frm_start;
    logic             frm_done;
    logic [5:0]       groups;
    logic [7:0]       desc_sel;

    assign groups   = q.clen[7:2];
    assign desc_sel = (q.i < 8'(DESC_LEN)) ? desc_byte[q.i[$clog2(DESC_LEN)-1:0]] : 8'h00;

    always_comb begin
        d          = q;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        mem_addr   = q.addr + ADDR_W'(q.i);
        mem_wdata  = 8'h00;
        buf_idx    = 8'd0;
        rb_we      = 1'b0;
        rb_widx    = q.i[IDX_W-1:0];
        rb_wdata   = mem_rdata;
        frm_start  = 1'b0;
        cmd_accept = 1'b0;
        unique case (q.state)
            S_IDLE: if (cmd_valid) begin
                d.op   = cmd_fn;
                d.clen = cmd_len;
                d.rfn  = cmd_fn;
                d.rlen = 8'd0;
                d.base = 8'd0;
                d.k    = 2'd0;
                d.i    = 8'd0;
                case (cmd_fn)
                    FN_STATUS: begin
                        d.rlen  = 8'(DESC_LEN);
                        d.state = S_DESC;
                    end
                    FN_RDMEM, FN_WRMEM, FN_PIN, FN_POUT: d.state = S_FETCH;
                    FN_SETB: d.state = (cmd_len[7:2] == 6'd0) ? S_SEND : S_FETCH;
                    default: begin
                        d.rfn   = FN_ERR;
                        d.stat  = 8'd1;
                        d.state = S_STAT;
                    end
                endcase
            end
            S_DESC: begin
                rb_we    = 1'b1;
                rb_wdata = desc_sel;
                d.i      = q.i + 8'd1;
                if (q.i == 8'(DESC_LEN - 1)) d.state = S_SEND;
            end
            S_FETCH: begin
                buf_idx      = q.base + 8'(q.k);
                d.arg[q.k]   = buf_data;
                d.k          = q.k + 2'd1;
                if (q.k == 2'd3) d.state = S_DISPATCH;
            end
            S_DISPATCH: begin
                d.i    = 8'd0;
                d.addr = ADDR_W'({q.arg[2], q.arg[1]});
                case (q.op)
                    FN_RDMEM: begin
                        d.cnt   = (q.arg[3] > 8'(BUF_DEPTH)) ? 8'(BUF_DEPTH) : q.arg[3];
                        d.rlen  = d.cnt;
                        d.state = (d.cnt == 8'd0) ? S_SEND : S_RD_REQ;
                    end
                    FN_WRMEM: begin
                        d.cnt = (q.clen > 8'd3) ? q.clen - 8'd3 : 8'd0;
                        if (d.cnt == 8'd0) begin
                            d.stat  = 8'd0;
                            d.state = S_STAT;
                        end else begin
                            d.state = S_WR;
                        end
                    end
                    FN_SETB: d.state = S_SB_RD;
                    FN_PIN: begin
                        mem_rd   = 1'b1;
                        mem_addr = ADDR_W'({q.arg[1], q.arg[0]});
                        d.state  = S_PIN_CAP;
                    end
                    default: begin
                        mem_wr    = 1'b1;
                        mem_addr  = ADDR_W'({q.arg[1], q.arg[0]});
                        mem_wdata = q.arg[2];
                        d.stat    = 8'd0;
                        d.state   = S_STAT;
                    end
                endcase
            end
            S_RD_REQ: begin
                mem_rd  = 1'b1;
                d.state = S_RD_CAP;
            end
            S_RD_CAP: begin
                rb_we = 1'b1;
                d.i   = q.i + 8'd1;
                d.state = (q.i + 8'd1 == q.cnt) ? S_SEND : S_RD_REQ;
            end
            S_WR: begin
                buf_idx   = 8'd3 + q.i;
                mem_wr    = 1'b1;
                mem_wdata = buf_data;
                d.i       = q.i + 8'd1;
                if (q.i + 8'd1 == q.cnt) begin
                    d.i     = 8'd0;
                    d.state = S_VRD;
                end
            end
            S_VRD: begin
                mem_rd  = 1'b1;
                d.state = S_VCMP;
            end
            S_VCMP: begin
                buf_idx = 8'd3 + q.i;
                if (mem_rdata != buf_data) begin
                    d.stat  = 8'd1;
                    d.state = S_STAT;
                end else if (q.i + 8'd1 == q.cnt) begin
                    d.stat  = 8'd0;
                    d.state = S_STAT;
                end else begin
                    d.i     = q.i + 8'd1;
                    d.state = S_VRD;
                end
            end
            S_SB_RD: begin
                mem_rd  = 1'b1;
                d.state = S_SB_WR;
            end
            S_SB_WR: begin
                d.old     = mem_rdata;
                mem_wr    = 1'b1;
                mem_wdata = q.arg[3];
                d.state   = S_SB_VRD;
            end
            S_SB_VRD: begin
                mem_rd  = 1'b1;
                d.state = S_SB_CMP;
            end
            S_SB_CMP: begin
                if (mem_rdata == q.arg[3]) begin
                    rb_we    = 1'b1;
                    rb_widx  = q.rlen[IDX_W-1:0];
                    rb_wdata = q.old;
                    d.rlen   = q.rlen + 8'd1;
                    if (q.rlen + 8'd1 == {2'b00, groups}) begin
                        d.state = S_SEND;
                    end else begin
                        d.base  = q.base + 8'd4;
                        d.k     = 2'd0;
                        d.state = S_FETCH;
                    end
                end else begin
                    d.state = S_SEND;
                end
            end
            S_PIN_CAP: begin
                d.stat  = mem_rdata;
                d.state = S_STAT;
            end
            S_STAT: begin
                rb_we    = 1'b1;
                rb_widx  = '0;
                rb_wdata = q.stat;
                d.rlen   = 8'd1;
                d.state  = S_SEND;
            end
            S_SEND: begin
                frm_start = 1'b1;
                d.state   = S_WAIT;
            end
            S_WAIT: if (frm_done) d.state = S_ACK;
            S_ACK: begin
                cmd_accept = 1'b1;
                d.state    = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    dbg_reply_buf #(.DEPTH(BUF_DEPTH)) u_rbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rb_we),
        .widx  (rb_widx),
        .wdata (rb_wdata),
        .ridx  (rb_ridx),
        .rdata (rb_rdata)
    );

    dbg_tx_framer #(.DEPTH(BUF_DEPTH)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (frm_start),
        .fn       (q.rfn),
        .len      (q.rlen),
        .rd_idx   (rb_ridx),
        .rd_data  (rb_rdata),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .done     (frm_done)
    );

    // R12: one strobe per cycle
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6: set-bytes write is read back on the very next cycle, same address
    p_verify_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_SB_WR) |=> (mem_rd && $stable(mem_addr)));

    // R11: accept is a single pulse
    p_accept_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> !cmd_accept);

    // R11: accept comes right after a byte handshake
    p_accept_after_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> $past(tx_valid && tx_ready));

    // R2: reply streaming never overlaps bus traffic
    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/dbg_cmd_exec_test.sv
module dbg_cmd_exec_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [7:0]  cmd_fn, cmd_len;
    logic        cmd_accept;
    logic [7:0]  buf_idx, buf_data;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        tx_valid, tx_ready;
    logic [7:0]  tx_data;

    always #5 clk = ~clk;

    dbg_cmd_exec uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_fn(cmd_fn),
        .cmd_len(cmd_len), .cmd_accept(cmd_accept), .buf_idx(buf_idx),
        .buf_data(buf_data), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    logic [7:0] pay [0:255];
    logic [7:0] mem [0:1023];
    logic [7:0] rx  [0:139];
    logic [7:0] ex  [0:139];
    int rx_n, acc_at, rd_cnt, wr_cnt, overlap, hold_err;
    int tests, fails;

    assign buf_data = pay[buf_idx];

    // memory model: 0xE000-0xEFFF is read-only and reads back ~addr[7:0]
    always @(posedge clk) begin
        if (mem_wr && mem_addr[15:12] != 4'hE) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= (mem_addr[15:12] == 4'hE) ? ~mem_addr[7:0] : mem[mem_addr[9:0]];
        if (mem_rd) rd_cnt <= rd_cnt + 1;
        if (mem_wr) wr_cnt <= wr_cnt + 1;
        if (mem_rd && mem_wr) overlap <= overlap + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [7:0] fn, input logic [7:0] len, input bit stall);
        int cyc = 0;
        bit hold_p = 0;
        logic [7:0] hold_d = 8'h00;
        rx_n = 0;
        acc_at = -1;
        @(negedge clk);
        cmd_fn = fn; cmd_len = len; cmd_valid = 1'b1;
        while (acc_at < 0 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (hold_p && (!tx_valid || tx_data != hold_d)) hold_err++;
            hold_p = 0;
            if (cmd_accept) begin
                acc_at = rx_n;
                cmd_valid = 1'b0;
                tx_ready = 1'b0;
            end else begin
                tx_ready = stall ? (cyc % 3 != 1) : 1'b1;
                if (tx_valid && tx_ready) begin
                    if (rx_n < 140) rx[rx_n] = tx_data;
                    rx_n++;
                end else if (tx_valid) begin
                    hold_p = 1; hold_d = tx_data;
                end
            end
        end
    endtask

    task automatic check_frame(input string req, input logic [7:0] efn, input int elen);
        logic [7:0] s = 8'h00;
        chk(rx_n == elen + 3, {req, " R2 frame size"}, rx_n, elen + 3);
        chk(rx[0] == efn, {req, " function"}, rx[0], efn);
        chk(rx[1] == 8'(elen), {req, " length"}, rx[1], elen);
        for (int j = 0; j < elen && j < 137; j++)
            chk(rx[2+j] == ex[j], {req, " data"}, rx[2+j], ex[j]);
        for (int j = 0; j < rx_n && j < 140; j++) s = s + rx[j];
        chk(s == 8'h00, "R2 checksum", s, 0);
        chk(acc_at == rx_n, "R11 accept after last byte", acc_at, rx_n);
    endtask

    task automatic t_reset;
        chk(!tx_valid && !cmd_accept && !mem_rd && !mem_wr, "R1 reset outputs",
            {tx_valid, cmd_accept, mem_rd, mem_wr}, 0);
    endtask

    task automatic t_status;
        logic [7:0] dsc [9] = '{8'h05, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h3F};
        for (int j = 0; j < 9; j++) ex[j] = dsc[j];
        run_cmd(8'hFF, 8'd0, 1'b1);
        check_frame("R3 status", 8'hFF, 9);
    endtask

    task automatic t_unknown;
        int r0 = rd_cnt, w0 = wr_cnt;
        ex[0] = 8'h01;
        run_cmd(8'hFC, 8'd0, 1'b0);
        check_frame("R10 unknown", 8'hF0, 1);
        chk(rd_cnt == r0 && wr_cnt == w0, "R10 no bus strobe", rd_cnt + wr_cnt, r0 + w0);
    endtask

    task automatic t_read;
        pay[0] = 8'h33; pay[1] = 8'h10; pay[2] = 8'h03; pay[3] = 8'd5;
        for (int j = 0; j < 5; j++) ex[j] = mem[10'h310 + j];
        run_cmd(8'hFE, 8'd4, 1'b1);
        check_frame("R4 read", 8'hFE, 5);
        pay[1] = 8'h00; pay[2] = 8'h00; pay[3] = 8'd200;
        for (int j = 0; j < 128; j++) ex[j] = mem[j];
        run_cmd(8'hFE, 8'd4, 1'b0);
        check_frame("R4 read clamp", 8'hFE, 128);
        pay[3] = 8'd0;
        run_cmd(8'hFE, 8'd4, 1'b0);
        check_frame("R4 read zero", 8'hFE, 0);
    endtask

    task automatic t_write;
        pay[0] = 8'h00; pay[1] = 8'h20; pay[2] = 8'h02;
        pay[3] = 8'hC1; pay[4] = 8'hC2; pay[5] = 8'hC3;
        ex[0] = 8'h00;
        run_cmd(8'hFD, 8'd6, 1'b0);
        check_frame("R5 write ok", 8'hFD, 1);
        for (int j = 0; j < 3; j++)
            chk(mem[10'h220 + j] == pay[3+j], "R5 memory written", mem[10'h220 + j], pay[3+j]);
        pay[1] = 8'h10; pay[2] = 8'hE0;
        ex[0] = 8'h01;
        run_cmd(8'hFD, 8'd5, 1'b1);
        check_frame("R5 write verify fail", 8'hFD, 1);
    endtask

    task automatic t_setb;
        logic [15:0] a [3] = '{16'h0040, 16'h0141, 16'h0242};
        for (int g = 0; g < 3; g++) begin
            pay[4*g] = 8'h00; pay[4*g+1] = a[g][7:0]; pay[4*g+2] = a[g][15:8];
            pay[4*g+3] = 8'h3F;
            ex[g] = mem[a[g][9:0]];
        end
        pay[12] = 8'h99;
        run_cmd(8'hF9, 8'd13, 1'b1);
        check_frame("R6 set bytes", 8'hF9, 3);
        for (int g = 0; g < 3; g++)
            chk(mem[a[g][9:0]] == 8'h3F, "R6 new byte stored", mem[a[g][9:0]], 8'h3F);
    endtask

    task automatic t_setb_abort;
        logic [7:0] keep = mem[10'h060];
        pay[0] = 8'h00; pay[1] = 8'h50; pay[2] = 8'h00; pay[3] = 8'h3F;
        pay[4] = 8'h00; pay[5] = 8'h20; pay[6] = 8'hE0; pay[7] = 8'h3F;
        pay[8] = 8'h00; pay[9] = 8'h60; pay[10] = 8'h00; pay[11] = 8'h3F;
        ex[0] = mem[10'h050];
        run_cmd(8'hF9, 8'd12, 1'b0);
        check_frame("R7 set abort", 8'hF9, 1);
        chk(mem[10'h060] == keep, "R7 later group untouched", mem[10'h060], keep);
    endtask

    task automatic t_ports;
        int r0;
        mem[10'h377] = 8'hA5;
        pay[0] = 8'h77; pay[1] = 8'h03;
        ex[0] = 8'hA5;
        run_cmd(8'hF8, 8'd2, 1'b0);
        check_frame("R8 port in", 8'hF8, 1);
        pay[0] = 8'h88; pay[1] = 8'h03; pay[2] = 8'h5C;
        ex[0] = 8'h00;
        r0 = rd_cnt;
        run_cmd(8'hF7, 8'd3, 1'b0);
        check_frame("R9 port out", 8'hF7, 1);
        chk(mem[10'h388] == 8'h5C, "R9 byte written", mem[10'h388], 8'h5C);
        chk(rd_cnt == r0, "R9 no read strobe", rd_cnt, r0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tests = 0; fails = 0; rd_cnt = 0; wr_cnt = 0; overlap = 0; hold_err = 0;
        for (int j = 0; j < 1024; j++) mem[j] = 8'(j * 7 + 3);
        for (int j = 0; j < 256; j++) pay[j] = 8'h00;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_fn = 8'h00; cmd_len = 8'h00; tx_ready = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_unknown();
        t_read();
        t_write();
        t_setb();
        t_setb_abort();
        t_ports();
        chk(overlap == 0, "R12 strobes never overlap", overlap, 0);
        chk(hold_err == 0, "R13 byte held under stall", hold_err, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule